// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is a byte-wide configuration register file that sits behind a pair of host I/O ports: an index port at a fixed base address and a data port at base+1. After reset the register file is hidden. Every port read returns 0xFF, and a write can change no register. The host opens it by writing a four-byte key to the index port. The last byte of that key depends on which of the two supported base addresses the instance was built for.

Once the block is open, a write to the index port picks a register and the data port reads or writes it. The file holds a 16-bit chip identifier, a logical-device selector, a global flash-control register with five live bits, and a 16-bit I/O base address that is reachable only while logical device 7 is selected. A write to the exit register closes the block again, after which the full key is needed to reopen it. Read data is registered and is valid in the cycle after the read strobe.

Top module: `cfg_unlock_ctrl`

## Requirements
- R1: After reset the block is locked, `io_rdata` is 0xFF, the logical-device selector is 0 and the index is 0x00. While locked, a read of either port returns 0xFF.
- R2: The index-port bytes 0x87, 0x01, 0x55 and then a fourth byte unlock the block. The fourth byte must be 0x55 for base 0x2E and 0xAA for base 0x4E; any other fourth byte leaves the block locked.
- R3: A byte that does not match the expected key byte restarts matching. If that byte is 0x87, it counts as the first key byte. Reads do not disturb matching.
- R4: While locked, writes to either port change no register, including the index.
- R5: While unlocked, a write to the index port selects a register and a read of the index port returns the selected index. The data port reads and writes the selected register. Unused indexes read 0x00.
- R6: Indexes 0x20 and 0x21 return the high and low bytes of CHIP_ID (default 0x87 and 0x16). Writes to them have no effect.
- R7: Index 0x07 is the logical-device selector. It can be read and written.
- R8: Indexes 0x64 and 0x65 hold the high and low bytes of the I/O base (reset IOB_RESET, default 0x0820) only while the selector equals 7. With any other device selected they read 0x00 and ignore writes.
- R9: Index 0x24 keeps only bits 5 to 1 of a written byte. Bits 0, 6 and 7 read as 0.
- R10: Writing a byte with bit 1 set to index 0x02 locks the block and clears the index to 0x00. A byte with bit 1 clear has no effect.
- R11: Reads at any address other than the port pair return 0xFF, even while the block is unlocked. Read data appears in the cycle after `io_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |

## Verification
The hardest state to reach from the ports is a partly matched key that is then broken. A partial key leaves no mark on any output, and only the way the next bytes are treated shows how far matching had got. The bench therefore sweeps all 256 candidates for the fourth key byte on both base addresses and reads the data port after each attempt. It also sends key streams in which a repeated 0x87 or a broken prefix must restart matching, and it places reads in the middle of a key. Register contents are checked through exhaustive index sweeps, with expected values taken from an arithmetic model of the register map.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
   localparam logic [7:0] KEY_B0     = 8'h87;
   localparam logic [7:0] KEY_B1     = 8'h01;
   localparam logic [7:0] KEY_B2     = 8'h55;
   localparam logic [7:0] REG_EXIT   = 8'h02;
   localparam logic [7:0] REG_LDN    = 8'h07;
   localparam logic [7:0] REG_ID_HI  = 8'h20;
   localparam logic [7:0] REG_ID_LO  = 8'h21;
   localparam logic [7:0] REG_GCTL   = 8'h24;
   localparam logic [7:0] REG_IOB_HI = 8'h64;
   localparam logic [7:0] REG_IOB_LO = 8'h65;
   localparam logic [7:0] GCTL_MASK  = 8'h3E;
   localparam logic [7:0] LOCKED_RD  = 8'hFF;

   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_GOT0 = 2'd1,
      KS_GOT1 = 2'd2,
      KS_GOT2 = 2'd3
   } key_stage_e;
endpackage

// File: rtl/cfgu_key_match.sv
module cfgu_key_match
   import cfgu_pkg::*;
#(
   parameter int BASE_PORT = 'h2E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_byte,
   input  logic       relock,
   output logic       unlocked
);
   logic [7:0] key_last;
   logic [7:0] key_want;
   key_stage_e stage_q;

   generate
      if (BASE_PORT == 'h2E) begin : g_key_lo
         assign key_last = 8'h55;
      end else if (BASE_PORT == 'h4E) begin : g_key_hi
         assign key_last = 8'hAA;
      end else begin : g_key_bad
         $error("cfgu_key_match: BASE_PORT must be 0x2E or 0x4E");
         assign key_last = 8'h00;
      end
   endgenerate

   always_comb begin
      unique case (stage_q)
         KS_IDLE: key_want = KEY_B0;
         KS_GOT0: key_want = KEY_B1;
         KS_GOT1: key_want = KEY_B2;
         default: key_want = key_last;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q  <= KS_IDLE;
         unlocked <= 1'b0;
      end else if (relock) begin
         stage_q  <= KS_IDLE;
         unlocked <= 1'b0;
      end else if (key_wr && !unlocked) begin
         if (key_byte == key_want) begin
            unique case (stage_q)
               KS_IDLE: stage_q <= KS_GOT0;
               KS_GOT0: stage_q <= KS_GOT1;
               KS_GOT1: stage_q <= KS_GOT2;
               default: begin
                  stage_q  <= KS_IDLE;
                  unlocked <= 1'b1;
               end
            endcase
         end else begin
            stage_q <= (key_byte == KEY_B0) ? KS_GOT0 : KS_IDLE;
         end
      end
   end

   // R2: opening only ever follows an index write of the final key byte
   a_r2_open_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(key_wr && key_byte == key_last));

   // R3: a broken prefix that is not 0x87 drops back to the idle stage
   a_r3_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && !unlocked && !relock && key_byte != key_want && key_byte != KEY_B0)
      |=> stage_q == KS_IDLE);

   // R10: a relock pulse always closes the block
   a_r10_relock_closes: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> !unlocked);
endmodule

// File: rtl/cfgu_reg_bank.sv
module cfgu_reg_bank
   import cfgu_pkg::*;
#(
   parameter logic [15:0] CHIP_ID   = 16'h8716,
   parameter logic [15:0] IOB_RESET = 16'h0820,
   parameter logic [7:0]  IOB_LDN   = 8'h07
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       unlocked,
   input  logic       idx_wr,
   input  logic       dat_wr,
   input  logic [7:0] wbyte,
   output logic [7:0] idx_q,
   output logic [7:0] reg_rd,
   output logic       relock
);
   localparam int IOB_BYTES = 2;

   logic [7:0] ldn_q;
   logic [7:0] gctl_q;
   logic [7:0] iob_byte [IOB_BYTES];
   logic       dev_open;
   logic       reg_wr;

   assign reg_wr   = unlocked && dat_wr;
   assign dev_open = (ldn_q == IOB_LDN);
   assign relock   = reg_wr && (idx_q == REG_EXIT) && wbyte[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= 8'h00;
         ldn_q  <= 8'h00;
         gctl_q <= 8'h00;
      end else begin
         if (relock)
            idx_q <= 8'h00;
         else if (unlocked && idx_wr)
            idx_q <= wbyte;
         if (reg_wr && idx_q == REG_LDN)
            ldn_q <= wbyte;
         if (reg_wr && idx_q == REG_GCTL)
            gctl_q <= wbyte & GCTL_MASK;
      end
   end

   generate
      for (genvar b = 0; b < IOB_BYTES; b++) begin : g_iob
         localparam logic [7:0] MY_IDX = (b == 0) ? REG_IOB_LO : REG_IOB_HI;
         logic [7:0] byte_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               byte_q <= IOB_RESET[b*8 +: 8];
            else if (reg_wr && dev_open && idx_q == MY_IDX)
               byte_q <= wbyte;
         end
         assign iob_byte[b] = byte_q;
      end
   endgenerate

   always_comb begin
      unique case (idx_q)
         REG_LDN:    reg_rd = ldn_q;
         REG_ID_HI:  reg_rd = CHIP_ID[15:8];
         REG_ID_LO:  reg_rd = CHIP_ID[7:0];
         REG_GCTL:   reg_rd = gctl_q;
         REG_IOB_HI: reg_rd = dev_open ? iob_byte[1] : 8'h00;
         REG_IOB_LO: reg_rd = dev_open ? iob_byte[0] : 8'h00;
         default:    reg_rd = 8'h00;
      endcase
   end

   // R4: locked data writes leave every stored register untouched
   a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && dat_wr) |=> ($stable(ldn_q) && $stable(gctl_q) && $stable(iob_byte[0])
                                 && $stable(iob_byte[1])));

   // R4: locked index writes leave the index untouched
   a_r4_locked_index: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && idx_wr) |=> $stable(idx_q));

   // R9: dead bits of the flash-control register stay clear
   a_r9_gctl_dead_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (gctl_q & ~GCTL_MASK) == 8'h00);

   // R10: the index reads back as zero right after a relock
   a_r10_index_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      relock |=> idx_q == 8'h00);

   // R8: the I/O base moves only while its device is selected
   a_r8_iob_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_open |=> ($stable(iob_byte[0]) && $stable(iob_byte[1])));
endmodule

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
   import cfgu_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          BASE_PORT = 'h2E,
   parameter logic [15:0] CHIP_ID   = 16'h8716,
   parameter logic [15:0] IOB_RESET = 16'h0820,
   parameter logic [7:0]  IOB_LDN   = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata
);
   localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE_PORT);
   localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE_PORT + 1);

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("cfg_unlock_ctrl: ADDR_W must be at least 8");
      end
      if (BASE_PORT + 1 >= (1 << ADDR_W)) begin : g_bad_base
         $error("cfg_unlock_ctrl: BASE_PORT does not fit in ADDR_W");
      end
   endgenerate

   logic       hit_idx, hit_dat;
   logic       idx_wr, dat_wr;
   logic       unlocked, relock;
   logic [7:0] idx_q, reg_rd;

   assign hit_idx = (io_addr == IDX_ADDR);
   assign hit_dat = (io_addr == DAT_ADDR);
   assign idx_wr  = io_wr && hit_idx;
   assign dat_wr  = io_wr && hit_dat;

   cfgu_key_match #(.BASE_PORT(BASE_PORT)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (idx_wr),
      .key_byte (io_wdata),
      .relock   (relock),
      .unlocked (unlocked)
   );

   cfgu_reg_bank #(
      .CHIP_ID   (CHIP_ID),
      .IOB_RESET (IOB_RESET),
      .IOB_LDN   (IOB_LDN)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .unlocked (unlocked),
      .idx_wr   (idx_wr),
      .dat_wr   (dat_wr),
      .wbyte    (io_wdata),
      .idx_q    (idx_q),
      .reg_rd   (reg_rd),
      .relock   (relock)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         io_rdata <= LOCKED_RD;
      else if (io_rd) begin
         if (!unlocked || !(hit_idx || hit_dat))
            io_rdata <= LOCKED_RD;
         else if (hit_idx)
            io_rdata <= idx_q;
         else
            io_rdata <= reg_rd;
      end
   end

   // R1: a read while locked yields 0xFF next cycle
   a_r1_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !unlocked) |=> io_rdata == LOCKED_RD);

   // R11: a read off the port pair yields 0xFF next cycle
   a_r11_off_pair_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !hit_idx && !hit_dat) |=> io_rdata == LOCKED_RD);

   // R11: without a read strobe the read byte holds
   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/test_cfg_unlock_ctrl.sv
module test_cfg_unlock_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  rdata_a, rdata_b;

   int n_vec = 0;
   int n_bad = 0;

   always #5ns clk = ~clk;

   cfg_unlock_ctrl i_cfg_unlock_ctrl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_a));

   cfg_unlock_ctrl #(.BASE_PORT('h4E), .IOB_RESET(16'h0300)) i_cfg_unlock_ctrl_alt (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_b));

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic iow(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic ior(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      d = (a >= 16'h0040) ? rdata_b : rdata_a;
   endtask

   task automatic key(input logic [15:0] base, input logic [7:0] last);
      iow(base, 8'h87); iow(base, 8'h01); iow(base, 8'h55); iow(base, last);
   endtask

   task automatic leave(input logic [15:0] base);
      iow(base, 8'h02); iow(base + 16'd1, 8'h02);
   endtask

   task automatic reg_rd(input logic [15:0] base, input logic [7:0] idx, output logic [7:0] d);
      iow(base, idx); ior(base + 16'd1, d);
   endtask

   task automatic reg_wr(input logic [15:0] base, input logic [7:0] idx, input logic [7:0] v);
      iow(base, idx); iow(base + 16'd1, v);
   endtask

   function automatic logic [7:0] model(input logic [7:0] idx, input logic [7:0] ldn,
                                        input logic [7:0] gctl, input logic [15:0] iob,
                                        input logic [15:0] id);
      case (idx)
         8'h07: return ldn;
         8'h20: return id[15:8];
         8'h21: return id[7:0];
         8'h24: return gctl;
         8'h64: return (ldn == 8'h07) ? iob[15:8] : 8'h00;
         8'h65: return (ldn == 8'h07) ? iob[7:0] : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   initial begin
      #2ms;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 rdata after reset", rdata_a, 8'hFF);
      ior(16'h002F, d); chk("R1 locked data read", d, 8'hFF);
      ior(16'h002E, d); chk("R1 locked index read", d, 8'hFF);
      ior(16'h004F, d); chk("R1 alt locked data read", d, 8'hFF);

      // R4: locked writes on both ports
      iow(16'h002F, 8'hFF);
      iow(16'h002E, 8'h24);
      iow(16'h002F, 8'h3E);
      key(16'h002E, 8'h55);
      ior(16'h002E, d); chk("R4 index untouched by key", d, 8'h00);
      reg_rd(16'h002E, 8'h07, d); chk("R1 ldn reset 0", d, 8'h00);
      reg_rd(16'h002E, 8'h24, d); chk("R4 gctl untouched", d, 8'h00);

      // R6 chip id, read-only
      reg_rd(16'h002E, 8'h20, d); chk("R6 id hi", d, 8'h87);
      reg_rd(16'h002E, 8'h21, d); chk("R6 id lo", d, 8'h16);
      reg_wr(16'h002E, 8'h20, 8'h00);
      reg_wr(16'h002E, 8'h21, 8'hFF);
      reg_rd(16'h002E, 8'h20, d); chk("R6 id hi after write", d, 8'h87);
      reg_rd(16'h002E, 8'h21, d); chk("R6 id lo after write", d, 8'h16);

      // R9 full sweep of the flash-control register
      iow(16'h002E, 8'h24);
      for (int v = 0; v < 256; v++) begin
         iow(16'h002F, 8'(v));
         ior(16'h002F, d);
         chk("R9 gctl mask", d, 8'(v) & 8'h3E);
      end

      // R7 / R8 device select and I/O base
      reg_wr(16'h002E, 8'h07, 8'h07);
      reg_rd(16'h002E, 8'h07, d); chk("R7 ldn readback", d, 8'h07);
      reg_rd(16'h002E, 8'h64, d); chk("R8 iob hi reset", d, 8'h08);
      reg_rd(16'h002E, 8'h65, d); chk("R8 iob lo reset", d, 8'h20);
      reg_wr(16'h002E, 8'h64, 8'hA5);
      reg_wr(16'h002E, 8'h65, 8'h3C);
      reg_wr(16'h002E, 8'h07, 8'h03);
      reg_rd(16'h002E, 8'h07, d); chk("R7 ldn readback 3", d, 8'h03);
      reg_rd(16'h002E, 8'h64, d); chk("R8 iob hidden", d, 8'h00);
      reg_wr(16'h002E, 8'h64, 8'h11);
      reg_wr(16'h002E, 8'h07, 8'h07);
      reg_rd(16'h002E, 8'h64, d); chk("R8 iob hi kept", d, 8'hA5);
      reg_rd(16'h002E, 8'h65, d); chk("R8 iob lo kept", d, 8'h3C);

      // R5 full index sweep against the arithmetic model
      for (int i = 0; i < 256; i++) begin
         iow(16'h002E, 8'(i));
         ior(16'h002E, d); chk("R5 index readback", d, 8'(i));
         ior(16'h002F, d);
         chk("R5 register map", d, model(8'(i), 8'h07, 8'h3E, 16'hA53C, 16'h8716));
      end

      // R11 off-pair reads while open
      ior(16'h0030, d); chk("R11 off-pair read", d, 8'hFF);
      ior(16'h002D, d); chk("R11 below-pair read", d, 8'hFF);

      // R10 exit register
      reg_wr(16'h002E, 8'h02, 8'h01);
      ior(16'h002E, d); chk("R10 bit1 clear keeps open", d, 8'h02);
      iow(16'h002F, 8'h02);
      ior(16'h002F, d); chk("R10 relocked data", d, 8'hFF);
      ior(16'h002E, d); chk("R10 relocked index", d, 8'hFF);

      // R2 fourth-byte sweep, base 0x2E
      for (int k = 0; k < 256; k++) begin
         key(16'h002E, 8'(k));
         ior(16'h002F, d);
         chk("R2 fourth byte 2E", d, (k == 'h55) ? 8'h00 : 8'hFF);
         if (d != 8'hFF) leave(16'h002E);
      end
      ior(16'h002E, d); chk("R10 index cleared on relock", d, 8'hFF);

      // R3 restart behaviour
      iow(16'h002E, 8'h87); key(16'h002E, 8'h55);
      ior(16'h002F, d); chk("R3 repeated 87", d, 8'h00);
      leave(16'h002E);
      iow(16'h002E, 8'h87); iow(16'h002E, 8'h01); key(16'h002E, 8'h55);
      ior(16'h002F, d); chk("R3 restart after 87 01", d, 8'h00);
      leave(16'h002E);
      iow(16'h002E, 8'h87); iow(16'h002E, 8'h01); iow(16'h002E, 8'h00);
      iow(16'h002E, 8'h55); iow(16'h002E, 8'h55);
      ior(16'h002F, d); chk("R3 broken prefix stays locked", d, 8'hFF);
      iow(16'h002E, 8'h87); iow(16'h002E, 8'h01); iow(16'h002E, 8'h55);
      ior(16'h002F, d); chk("R3 partial key still locked", d, 8'hFF);
      iow(16'h002E, 8'h55);
      ior(16'h002F, d); chk("R3 read inside key harmless", d, 8'h00);
      ior(16'h004F, d); chk("R2 other base unaffected", d, 8'hFF);
      leave(16'h002E);

      // R2 alt base: 0x55 must not open, sweep fourth byte
      key(16'h004E, 8'h55);
      ior(16'h004F, d); chk("R2 alt rejects 55", d, 8'hFF);
      for (int k = 0; k < 256; k++) begin
         key(16'h004E, 8'(k));
         ior(16'h004F, d);
         chk("R2 fourth byte 4E", d, (k == 'hAA) ? 8'h00 : 8'hFF);
         if (d != 8'hFF) leave(16'h004E);
      end
      key(16'h004E, 8'hAA);
      reg_rd(16'h004E, 8'h20, d); chk("R6 alt id hi", d, 8'h87);
      reg_wr(16'h004E, 8'h07, 8'h07);
      reg_rd(16'h004E, 8'h64, d); chk("R8 alt iob hi reset", d, 8'h03);
      ior(16'h002F, d); chk("R1 main locked while alt open", d, 8'hFF);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule